// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block watches the access controls of the two ports of a shared dual-port memory and turns accesses to two reserved words at the top of the address space into one interrupt flag per port. The topmost address is the mailbox owned by the right port. The address one below it is the mailbox owned by the left port. A port that writes into the other port's mailbox raises that port's interrupt. The owner drops its interrupt by reading its own mailbox.

The mailbox data lives in the memory array next to this block. This block only tracks the two flags. Each port has a busy input from the address arbiter. While a port's busy is active, its accesses can neither raise the other side's flag nor clear its own. All inputs are sampled on the rising clock edge. A qualifying access seen in one cycle changes the flag at the end of that cycle.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is active, and immediately after it, both interrupt outputs are high (inactive). The interrupt outputs are active low.
- R2: A left-port write (select=1, write=1) to address all-ones, with left busy inactive, drives `rgt_irq_n` low at the clock edge that samples the write.
- R3: A right-port write to address all-ones minus one, with right busy inactive, drives `lft_irq_n` low at the clock edge that samples the write.
- R4: The owner clears its interrupt (output returns high) by reading its own mailbox. The read must have select=1, write=0 and output enable=1.
- R5: An owner read of its own mailbox with output enable inactive does not clear the interrupt.
- R6: A port that reads the other port's mailbox does not clear the other port's interrupt.
- R7: While a port's busy input is active (busy=1), its write to the peer mailbox does not raise the peer's interrupt.
- R8: While a port's busy input is active, its read of its own mailbox does not clear its interrupt.
- R9: If a set and a clear of the same interrupt occur in the same cycle, the set wins and the interrupt stays asserted.
- R10: None of the following changes either flag: writes to any non-mailbox address, a write by a port into its own mailbox, or any access with select inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_sel | input | 1 | Left port memory select, active high |
| lft_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| lft_oe | input | 1 | Left port output enable, active high |
| lft_addr | input | ADDR_W | Left port address |
| lft_busy | input | 1 | Left port busy from the arbiter (active high by default) |
| rgt_sel | input | 1 | Right port memory select, active high |
| rgt_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| rgt_oe | input | 1 | Right port output enable, active high |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_busy | input | 1 | Right port busy from the arbiter (active high by default) |
| lft_irq_n | output | 1 | Left port interrupt, active low |
| rgt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every flag change is due at the single rising edge that samples the qualifying access, which gives a latency of one edge and no further pipeline. The bench applies each access just after a falling edge and holds it for exactly one cycle. It then returns both ports to idle at the next falling edge and checks the flags there, half a period after the edge that should have updated them. For the cases where a flag must not change, the bench first places the flag in the state that the access could alter, and only then applies the access. Each of these checks reads the same flag again right after the one-cycle access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      PORT_LFT = 1'b0,
      PORT_RGT = 1'b1
   } mbx_port_e;

   localparam int unsigned MBX_NUM_PORTS = 2;

   // Decoded per-port events, already qualified by the port's busy input.
   typedef struct packed {
      logic set_peer;   // write that lands in the peer's mailbox
      logic clr_own;    // read of the port's own mailbox
   } mbx_evt_t;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int unsigned        ADDR_W       = 15,
   parameter logic [ADDR_W-1:0]  OWN_ADDR     = '1,
   parameter logic [ADDR_W-1:0]  PEER_ADDR    = '0,
   parameter bit                 BUSY_ACT_LOW = 1'b0
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              oe,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   output mbx_evt_t          evt
);

   logic busy_act;
   logic hit_own;
   logic hit_peer;

   if (OWN_ADDR == PEER_ADDR) begin : g_bad_map
      $error("mbx_port_dec: own and peer mailbox addresses coincide");
   end

   if (BUSY_ACT_LOW) begin : g_busy_low
      assign busy_act = ~busy;
   end else begin : g_busy_high
      assign busy_act = busy;
   end

   assign hit_own  = (addr == OWN_ADDR);
   assign hit_peer = (addr == PEER_ADDR);

   always_comb begin
      evt          = '0;
      evt.set_peer = sel & wr & hit_peer & ~busy_act;
      evt.clr_own  = sel & ~wr & oe & hit_own & ~busy_act;
   end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n <= 1'b1;
      end else if (set) begin
         irq_n <= 1'b0;
      end else if (clr) begin
         irq_n <= 1'b1;
      end
   end

   // R9: a set always leaves the flag asserted, even with a clear alongside
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> !irq_n);

   // R4: a clear without a set releases the flag
   a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> irq_n);

   // R10: with no event the flag holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W       = 15,
   parameter bit          BUSY_ACT_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lft_sel,
   input  logic              lft_wr,
   input  logic              lft_oe,
   input  logic [ADDR_W-1:0] lft_addr,
   input  logic              lft_busy,
   input  logic              rgt_sel,
   input  logic              rgt_wr,
   input  logic              rgt_oe,
   input  logic [ADDR_W-1:0] rgt_addr,
   input  logic              rgt_busy,
   output logic              lft_irq_n,
   output logic              rgt_irq_n
);

   localparam logic [ADDR_W-1:0] MBX_RGT = '1;
   localparam logic [ADDR_W-1:0] MBX_LFT = MBX_RGT - 1'b1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("mbx_irq_ctrl: ADDR_W must be at least 2");
   end

   logic              sel_v  [MBX_NUM_PORTS];
   logic              wr_v   [MBX_NUM_PORTS];
   logic              oe_v   [MBX_NUM_PORTS];
   logic [ADDR_W-1:0] addr_v [MBX_NUM_PORTS];
   logic              busy_v [MBX_NUM_PORTS];
   mbx_evt_t          evt_v  [MBX_NUM_PORTS];
   logic              irq_v  [MBX_NUM_PORTS];

   assign sel_v[PORT_LFT]  = lft_sel;
   assign wr_v[PORT_LFT]   = lft_wr;
   assign oe_v[PORT_LFT]   = lft_oe;
   assign addr_v[PORT_LFT] = lft_addr;
   assign busy_v[PORT_LFT] = lft_busy;
   assign sel_v[PORT_RGT]  = rgt_sel;
   assign wr_v[PORT_RGT]   = rgt_wr;
   assign oe_v[PORT_RGT]   = rgt_oe;
   assign addr_v[PORT_RGT] = rgt_addr;
   assign busy_v[PORT_RGT] = rgt_busy;

   for (genvar p = 0; p < MBX_NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? MBX_LFT : MBX_RGT;
      localparam logic [ADDR_W-1:0] PEER = (p == 0) ? MBX_RGT : MBX_LFT;

      mbx_port_dec #(
         .ADDR_W       (ADDR_W),
         .OWN_ADDR     (OWN),
         .PEER_ADDR    (PEER),
         .BUSY_ACT_LOW (BUSY_ACT_LOW)
      ) u_dec (
         .sel  (sel_v[p]),
         .wr   (wr_v[p]),
         .oe   (oe_v[p]),
         .addr (addr_v[p]),
         .busy (busy_v[p]),
         .evt  (evt_v[p])
      );

      mbx_irq_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (evt_v[MBX_NUM_PORTS-1-p].set_peer),
         .clr   (evt_v[p].clr_own),
         .irq_n (irq_v[p])
      );
   end

   assign lft_irq_n = irq_v[PORT_LFT];
   assign rgt_irq_n = irq_v[PORT_RGT];

   logic lft_busy_act;
   logic rgt_busy_act;
   assign lft_busy_act = lft_busy ^ BUSY_ACT_LOW;
   assign rgt_busy_act = rgt_busy ^ BUSY_ACT_LOW;

   // R1: flags are inactive while reset is held
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (lft_irq_n && rgt_irq_n));

   // R7: a busy writer cannot raise the peer flag
   a_r7_busy_blocks_set_rgt: assert property (@(posedge clk) disable iff (!rst_n)
      lft_busy_act |=> !$fell(rgt_irq_n));
   a_r7_busy_blocks_set_lft: assert property (@(posedge clk) disable iff (!rst_n)
      rgt_busy_act |=> !$fell(lft_irq_n));

   // R8: a busy owner cannot clear its own flag
   a_r8_busy_blocks_clr_rgt: assert property (@(posedge clk) disable iff (!rst_n)
      rgt_busy_act |=> !$rose(rgt_irq_n));
   a_r8_busy_blocks_clr_lft: assert property (@(posedge clk) disable iff (!rst_n)
      lft_busy_act |=> !$rose(lft_irq_n));

   // R2: an unblocked left write of the right mailbox raises the right flag
   a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
      (lft_sel && lft_wr && lft_addr == MBX_RGT && !lft_busy_act) |=> !rgt_irq_n);

   // R3: an unblocked right write of the left mailbox raises the left flag
   a_r3_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
      (rgt_sel && rgt_wr && rgt_addr == MBX_LFT && !rgt_busy_act) |=> !lft_irq_n);

endmodule

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;

   localparam int unsigned AW = 15;
   localparam logic [AW-1:0] A_RGT = 15'h7FFF;
   localparam logic [AW-1:0] A_LFT = 15'h7FFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lft_sel = 0, lft_wr = 0, lft_oe = 0, lft_busy = 0;
   logic rgt_sel = 0, rgt_wr = 0, rgt_oe = 0, rgt_busy = 0;
   logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
   logic lft_irq_n, rgt_irq_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_oe(lft_oe),
      .lft_addr(lft_addr), .lft_busy(lft_busy),
      .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_oe(rgt_oe),
      .rgt_addr(rgt_addr), .rgt_busy(rgt_busy),
      .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // One access cycle on both ports, then idle; called just after a falling edge.
   task automatic step(input logic ls, lw, lo, input logic [AW-1:0] la, input logic lb,
                       input logic rs, rw, ro, input logic [AW-1:0] ra, input logic rb);
      lft_sel = ls; lft_wr = lw; lft_oe = lo; lft_addr = la; lft_busy = lb;
      rgt_sel = rs; rgt_wr = rw; rgt_oe = ro; rgt_addr = ra; rgt_busy = rb;
      @(negedge clk);
      lft_sel = 0; lft_wr = 0; lft_oe = 0; lft_addr = '0; lft_busy = 0;
      rgt_sel = 0; rgt_wr = 0; rgt_oe = 0; rgt_addr = '0; rgt_busy = 0;
   endtask

   task automatic t_reset();
      chk("R1 lft after reset", lft_irq_n, 1'b1);
      chk("R1 rgt after reset", rgt_irq_n, 1'b1);
   endtask

   task automatic t_set_right();
      step(1,1,0,A_RGT,0, 0,0,0,'0,0);
      chk("R2 rgt set by left write", rgt_irq_n, 1'b0);
      chk("R2 lft untouched", lft_irq_n, 1'b1);
   endtask

   task automatic t_peer_read();
      step(1,0,1,A_RGT,0, 0,0,0,'0,0);
      chk("R6 left reading right mailbox keeps rgt", rgt_irq_n, 1'b0);
   endtask

   task automatic t_no_oe();
      step(0,0,0,'0,0, 1,0,0,A_RGT,0);
      chk("R5 read without oe keeps rgt", rgt_irq_n, 1'b0);
   endtask

   task automatic t_busy_clear();
      step(0,0,0,'0,0, 1,0,1,A_RGT,1);
      chk("R8 busy owner read keeps rgt", rgt_irq_n, 1'b0);
   endtask

   task automatic t_clear_right();
      step(0,0,0,'0,0, 1,0,1,A_RGT,0);
      chk("R4 owner read clears rgt", rgt_irq_n, 1'b1);
   endtask

   task automatic t_set_clear_left();
      step(0,0,0,'0,0, 1,1,0,A_LFT,0);
      chk("R3 lft set by right write", lft_irq_n, 1'b0);
      chk("R3 rgt untouched", rgt_irq_n, 1'b1);
      step(1,0,1,A_LFT,1, 0,0,0,'0,0);
      chk("R8 busy left read keeps lft", lft_irq_n, 1'b0);
      step(0,0,0,'0,0, 1,0,1,A_LFT,0);
      chk("R6 right reading left mailbox keeps lft", lft_irq_n, 1'b0);
      step(1,0,1,A_LFT,0, 0,0,0,'0,0);
      chk("R4 owner read clears lft", lft_irq_n, 1'b1);
   endtask

   task automatic t_busy_set();
      step(1,1,0,A_RGT,1, 0,0,0,'0,0);
      chk("R7 busy left write leaves rgt", rgt_irq_n, 1'b1);
      step(0,0,0,'0,0, 1,1,0,A_LFT,1);
      chk("R7 busy right write leaves lft", lft_irq_n, 1'b1);
   endtask

   task automatic t_other_addr();
      step(1,1,0,15'h1234,0, 1,1,0,15'h7FFD,0);
      chk("R10 non-mailbox writes rgt", rgt_irq_n, 1'b1);
      chk("R10 non-mailbox writes lft", lft_irq_n, 1'b1);
      step(1,1,0,A_LFT,0, 1,1,0,A_RGT,0);
      chk("R10 own-mailbox writes rgt", rgt_irq_n, 1'b1);
      chk("R10 own-mailbox writes lft", lft_irq_n, 1'b1);
      step(0,1,0,A_RGT,0, 0,1,0,A_LFT,0);
      chk("R10 deselected writes rgt", rgt_irq_n, 1'b1);
      chk("R10 deselected writes lft", lft_irq_n, 1'b1);
      // with flags set, deselected owner reads must not clear
      step(1,1,0,A_RGT,0, 1,1,0,A_LFT,0);
      step(0,0,1,A_LFT,0, 0,0,1,A_RGT,0);
      chk("R10 deselected read keeps rgt", rgt_irq_n, 1'b0);
      chk("R10 deselected read keeps lft", lft_irq_n, 1'b0);
   endtask

   task automatic t_collision();
      // both flags set from previous task; set and clear together
      step(1,0,1,A_LFT,0, 1,1,0,A_LFT,0);
      chk("R9 set wins over clear lft", lft_irq_n, 1'b0);
      step(1,1,0,A_RGT,0, 1,0,1,A_RGT,0);
      chk("R9 set wins over clear rgt", rgt_irq_n, 1'b0);
      step(1,0,1,A_LFT,0, 1,0,1,A_RGT,0);
      chk("R4 both owners clear together lft", lft_irq_n, 1'b1);
      chk("R4 both owners clear together rgt", rgt_irq_n, 1'b1);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_right();
      t_peer_read();
      t_no_oe();
      t_busy_clear();
      t_clear_right();
      t_set_clear_left();
      t_busy_set();
      t_other_addr();
      t_collision();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule